// File: doc/BRIEF.md
# Boot Source Latch with Low-Window Address Remap

This block decides, once per reset, which memory the system starts from. Two boot-select pins are read a fixed number of system clock rising edges after reset is released. The value read is held until the next reset, and later pin activity does not affect it. The held pair decodes to one of three sources: main flash, system memory or on-chip SRAM.

Bus addresses that fall in a low alias window starting at zero are remapped onto the physical base of the selected source. In flash mode the physical base is 0x0800_0000, and in system-memory mode it is 0x1FFF_D000. In SRAM mode the window is left unmapped and flagged, because software moves its own vector table there. Addresses outside the window pass through untouched. The window size and all base addresses are parameters.

Top module: `bootsel_remap`

## Requirements
- R1: `src_valid` is low after reset and for the first three rising clock edges after reset is released. The pins are sampled on the fourth rising edge, and `src_valid` is high from that edge on.
- R2: After the sample edge, changes on `boot_pin0`/`boot_pin1` leave `boot_src` and the address mapping unchanged until the next reset. A new reset samples again.
- R3: With `boot_pin0`=0 the source is main flash, encoded `boot_src`=2'b00, whatever the level of `boot_pin1`.
- R4: With `boot_pin1`=0 and `boot_pin0`=1 the source is system memory, encoded `boot_src`=2'b01.
- R5: With `boot_pin1`=1 and `boot_pin0`=1 the source is on-chip SRAM, encoded `boot_src`=2'b10. The code 2'b11 never appears.
- R6: In flash mode, an address below the window size (default 0x1_0000) translates to 0x0800_0000 + address, with `alias_hit`=1.
- R7: In system-memory mode, an in-window address translates to 0x1FFF_D000 + address, with `alias_hit`=1. The last window byte 0xFFFF maps to 0x2000_CFFF.
- R8: In SRAM mode, an in-window address passes through unchanged, with `alias_hit`=0 and `alias_unmapped`=1.
- R9: An address at or above the window size (for example 0x1_0000) passes through unchanged in every mode, with `alias_hit`=0 and `alias_unmapped`=0.
- R10: Before `src_valid` rises, `boot_src` reads 2'b00 and in-window addresses use the flash mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_pin0 | input | 1 | Boot-select pin, low selects flash |
| boot_pin1 | input | 1 | Boot-select pin, picks system memory or SRAM when pin0 is high |
| bus_addr | input | 32 | Bus address before remapping |
| phys_addr | output | 32 | Translated physical address |
| boot_src | output | 2 | Latched boot source code |
| src_valid | output | 1 | Pins have been sampled |
| alias_hit | output | 1 | Address was remapped through the window |
| alias_unmapped | output | 1 | In-window address with no remap (SRAM mode) |

## Verification
Each boot sequence holds the inverse pin pair during the first three edges after reset release and presents the wanted pair only just before the fourth edge. A capture on any other edge therefore yields a wrong code. After the capture, the pins are toggled to every other value over many cycles, which exposes a latch that keeps listening. All four pin pairs are tried, so the bench can tell apart a decoder that ignores `boot_pin1` when it should matter from one that consults it when `boot_pin0` is low. In each mode, addresses at zero, mid-window, the last window byte and the first byte past the window separate an off-by-one window bound from a wrong base or a missing pass-through.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;

   typedef enum logic [1:0] {
      SRC_FLASH  = 2'b00,
      SRC_SYSMEM = 2'b01,
      SRC_SRAM   = 2'b10
   } boot_src_e;

   // Pin pair order: [1] = pin1, [0] = pin0
   function automatic boot_src_e decode_pins(input logic [1:0] pins);
      boot_src_e r;
      if (!pins[0])      r = SRC_FLASH;
      else if (!pins[1]) r = SRC_SYSMEM;
      else               r = SRC_SRAM;
      return r;
   endfunction

endpackage

// File: rtl/bootsel_capture.sv
module bootsel_capture #(
   parameter int CAPTURE_EDGE = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin0,
   input  logic       pin1,
   output logic [1:0] pins_q,
   output logic       captured
);
   localparam int CNT_W = $clog2(CAPTURE_EDGE + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CAPTURE_EDGE - 1);
   localparam logic [CNT_W-1:0] SAT_CNT  = CNT_W'(CAPTURE_EDGE);

   generate
      if (CAPTURE_EDGE < 1) begin : g_bad_edge
         $error("CAPTURE_EDGE must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] edge_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         captured <= 1'b0;
         pins_q   <= 2'b00;
      end else if (!captured) begin
         edge_cnt <= edge_cnt + CNT_W'(1);
         if (edge_cnt == LAST_CNT) begin
            captured <= 1'b1;
            pins_q   <= {pin1, pin0};
         end
      end
   end

   // R1: counter never runs past its saturation value
   a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      edge_cnt <= SAT_CNT);

   // R1: the valid flag rises only on the edge that follows the last pre-capture count
   a_r1_rose_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(captured) |-> $past(edge_cnt) == LAST_CNT);

   // R1: the held pins equal the pin levels seen at the capture edge
   a_r1_sampled_value: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(captured) |-> pins_q == {$past(pin1), $past(pin0)});

   // R2: once captured, the held pins and the flag stay put
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      captured |=> (captured && $stable(pins_q)));

endmodule

// File: rtl/bootsel_decode.sv
module bootsel_decode
   import bootsel_pkg::*;
(
   input  logic       valid,
   input  logic [1:0] pins,
   output boot_src_e  src
);
   always_comb begin
      if (!valid) src = SRC_FLASH;
      else        src = decode_pins(pins);
   end
endmodule

// File: rtl/bootsel_rebase.sv
module bootsel_rebase #(
   parameter int ADDR_W = 32,
   parameter int WIN_BITS = 16,
   parameter logic [ADDR_W-1:0] BASE = '0
) (
   input  logic [WIN_BITS-1:0] offset,
   output logic [ADDR_W-1:0]   phys
);
   localparam bit ALIGNED = (BASE[WIN_BITS-1:0] == '0);

   generate
      if (ALIGNED) begin : g_concat
         assign phys = {BASE[ADDR_W-1:WIN_BITS], offset};
      end else begin : g_adder
         assign phys = BASE + {{(ADDR_W-WIN_BITS){1'b0}}, offset};
      end
   endgenerate
endmodule

// File: rtl/bootsel_xlate.sv
module bootsel_xlate
   import bootsel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int WIN_BYTES = 65536,
   parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0800_0000,
   parameter logic [ADDR_W-1:0] SYSMEM_BASE = 32'h1FFF_D000
) (
   input  logic [ADDR_W-1:0] addr,
   input  boot_src_e         src,
   output logic [ADDR_W-1:0] phys,
   output logic              hit,
   output logic              unmapped
);
   localparam int WIN_BITS = $clog2(WIN_BYTES);
   localparam int N_REGION = 2;

   generate
      if ((1 << WIN_BITS) != WIN_BYTES) begin : g_bad_win
         $error("WIN_BYTES must be a power of two");
      end
      if (WIN_BITS < 1 || WIN_BITS >= ADDR_W || ADDR_W > 62) begin : g_bad_w
         $error("window must be narrower than the address");
      end
      if ((longint'(FLASH_BASE) + longint'(WIN_BYTES)) > (longint'(1) << ADDR_W)) begin : g_bad_fb
         $error("flash window runs past the address space");
      end
      if ((longint'(SYSMEM_BASE) + longint'(WIN_BYTES)) > (longint'(1) << ADDR_W)) begin : g_bad_sb
         $error("system memory window runs past the address space");
      end
   endgenerate

   logic                in_win;
   logic [WIN_BITS-1:0] offset;
   logic [ADDR_W-1:0]   remap [N_REGION];

   assign in_win = (addr[ADDR_W-1:WIN_BITS] == '0);
   assign offset = addr[WIN_BITS-1:0];

   generate
      for (genvar g = 0; g < N_REGION; g++) begin : g_region
         localparam logic [ADDR_W-1:0] RB = (g == 0) ? FLASH_BASE : SYSMEM_BASE;
         bootsel_rebase #(
            .ADDR_W  (ADDR_W),
            .WIN_BITS(WIN_BITS),
            .BASE    (RB)
         ) u_rebase (
            .offset(offset),
            .phys  (remap[g])
         );
      end
   endgenerate

   always_comb begin
      phys     = addr;
      hit      = 1'b0;
      unmapped = 1'b0;
      if (in_win) begin
         case (src)
            SRC_FLASH: begin
               phys = remap[0];
               hit  = 1'b1;
            end
            SRC_SYSMEM: begin
               phys = remap[1];
               hit  = 1'b1;
            end
            default: unmapped = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/bootsel_remap.sv
module bootsel_remap
   import bootsel_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CAPTURE_EDGE = 4,
   parameter int WIN_BYTES = 65536,
   parameter logic [ADDR_W-1:0] FLASH_BASE  = 32'h0800_0000,
   parameter logic [ADDR_W-1:0] SYSMEM_BASE = 32'h1FFF_D000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boot_pin0,
   input  logic              boot_pin1,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic [ADDR_W-1:0] phys_addr,
   output logic [1:0]        boot_src,
   output logic              src_valid,
   output logic              alias_hit,
   output logic              alias_unmapped
);
   localparam logic [ADDR_W-1:0] WIN_LIMIT = ADDR_W'(WIN_BYTES);

   logic [1:0] pins_q;
   boot_src_e  src;

   bootsel_capture #(
      .CAPTURE_EDGE(CAPTURE_EDGE)
   ) u_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin0    (boot_pin0),
      .pin1    (boot_pin1),
      .pins_q  (pins_q),
      .captured(src_valid)
   );

   bootsel_decode u_decode (
      .valid(src_valid),
      .pins (pins_q),
      .src  (src)
   );

   bootsel_xlate #(
      .ADDR_W     (ADDR_W),
      .WIN_BYTES  (WIN_BYTES),
      .FLASH_BASE (FLASH_BASE),
      .SYSMEM_BASE(SYSMEM_BASE)
   ) u_xlate (
      .addr    (bus_addr),
      .src     (src),
      .phys    (phys_addr),
      .hit     (alias_hit),
      .unmapped(alias_unmapped)
   );

   assign boot_src = src;

   // R2: the source code cannot change while the latch is valid
   a_r2_src_stable: assert property (@(posedge clk) disable iff (!rst_n)
      src_valid |=> $stable(boot_src));

   // R5: the unused code never shows up
   a_r5_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
      boot_src != 2'b11);

   // R10: before the capture the source reads as flash
   a_r10_pre_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !src_valid |-> boot_src == 2'b00);

   // R6: flash-mode window lands on the flash base
   a_r6_flash_map: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_src == 2'b00 && bus_addr < WIN_LIMIT) |-> (alias_hit && phys_addr == FLASH_BASE + bus_addr));

   // R8: SRAM-mode window is left unmapped
   a_r8_sram_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
      (boot_src == 2'b10 && bus_addr < WIN_LIMIT) |-> (alias_unmapped && !alias_hit && phys_addr == bus_addr));

   // R9: addresses past the window pass straight through
   a_r9_outside: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr >= WIN_LIMIT) |-> (phys_addr == bus_addr && !alias_hit && !alias_unmapped));

endmodule

// File: tb/bootsel_remap_tb.sv
module bootsel_remap_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        boot_pin0 = 1'b0;
   logic        boot_pin1 = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] phys_addr;
   logic [1:0]  boot_src;
   logic        src_valid;
   logic        alias_hit;
   logic        alias_unmapped;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   bootsel_remap u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .boot_pin0     (boot_pin0),
      .boot_pin1     (boot_pin1),
      .bus_addr      (bus_addr),
      .phys_addr     (phys_addr),
      .boot_src      (boot_src),
      .src_valid     (src_valid),
      .alias_hit     (alias_hit),
      .alias_unmapped(alias_unmapped)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Probe one address; flags packed {hit, unmapped}
   task automatic probe(input string req, input logic [31:0] a,
                        input logic [31:0] exp_phys, input logic [1:0] exp_flags);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(req, phys_addr, exp_phys);
      chk(req, {30'b0, alias_hit, alias_unmapped}, {30'b0, exp_flags});
   endtask

   // Reset, hold inverse pins for three edges, present wanted pins for the fourth
   task automatic boot_seq(input logic p1, input logic p0, input logic [1:0] exp_code);
      @(negedge clk);
      rst_n = 1'b0;
      boot_pin1 = ~p1;
      boot_pin0 = ~p0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int e = 1; e <= 3; e++) begin
         @(posedge clk);
         #1;
         chk("R1 valid low before 4th edge", {31'b0, src_valid}, 32'd0);
      end
      @(negedge clk);
      boot_pin1 = p1;
      boot_pin0 = p0;
      @(posedge clk);
      #1;
      chk("R1 valid at 4th edge", {31'b0, src_valid}, 32'd1);
      chk("R3/R4/R5 code", {30'b0, boot_src}, {30'b0, exp_code});
   endtask

   task automatic t_reset_state;
      @(negedge clk);
      rst_n = 1'b0;
      bus_addr = 32'h0000_0100;
      #1;
      chk("R1 valid low in reset", {31'b0, src_valid}, 32'd0);
      chk("R10 code in reset", {30'b0, boot_src}, 32'd0);
      chk("R10 flash map before valid", phys_addr, 32'h0800_0100);
      chk("R10 hit before valid", {31'b0, alias_hit}, 32'd1);
   endtask

   task automatic t_flash;
      boot_seq(1'b0, 1'b0, 2'b00);
      probe("R6 flash zero", 32'h0000_0000, 32'h0800_0000, 2'b10);
      probe("R6 flash mid", 32'h0000_1234, 32'h0800_1234, 2'b10);
      probe("R6 flash last", 32'h0000_FFFF, 32'h0800_FFFF, 2'b10);
      probe("R9 flash past window", 32'h0001_0000, 32'h0001_0000, 2'b00);
      boot_seq(1'b1, 1'b0, 2'b00);
      probe("R3 pin1 ignored flash", 32'h0000_0040, 32'h0800_0040, 2'b10);
   endtask

   task automatic t_sysmem;
      boot_seq(1'b0, 1'b1, 2'b01);
      probe("R7 sysmem zero", 32'h0000_0000, 32'h1FFF_D000, 2'b10);
      probe("R7 sysmem mid", 32'h0000_1234, 32'h1FFF_E234, 2'b10);
      probe("R7 sysmem last", 32'h0000_FFFF, 32'h2000_CFFF, 2'b10);
      probe("R9 sysmem past window", 32'h0800_0004, 32'h0800_0004, 2'b00);
   endtask

   task automatic t_sram;
      boot_seq(1'b1, 1'b1, 2'b10);
      probe("R8 sram zero", 32'h0000_0000, 32'h0000_0000, 2'b01);
      probe("R8 sram last", 32'h0000_FFFF, 32'h0000_FFFF, 2'b01);
      probe("R9 sram physical", 32'h2000_0040, 32'h2000_0040, 2'b00);
   endtask

   task automatic t_ignore_after;
      boot_seq(1'b0, 1'b1, 2'b01);
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         boot_pin0 = k[0];
         boot_pin1 = k[1];
         @(posedge clk);
         #1;
         chk("R2 code held", {30'b0, boot_src}, 32'd1);
      end
      probe("R2 mapping held", 32'h0000_0010, 32'h1FFF_D010, 2'b10);
      boot_seq(1'b1, 1'b1, 2'b10);
      chk("R2 new reset resamples", {30'b0, boot_src}, 32'd2);
   endtask

   initial begin
      #(4 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      t_flash();
      t_sysmem();
      t_sram();
      t_ignore_after();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule